// File: doc/BRIEF.md
# Left-to-right binary-field power engine

This block raises a field element to an integer power in GF(2^m), with m set by a parameter. The field is given by a monic polynomial of degree m. The caller supplies the base, the exponent and the low m coefficients of that polynomial as one operand set. The engine returns base^exponent reduced modulo the polynomial.

The exponent is scanned from its top bit down. The top bit seeds the running value: it is the base when that bit is set and the constant 1 when it is clear. Each later bit then costs one pass through a bit-serial multiplier that forms X·Y² mod P in m clock cycles. X is the base when the current bit is set and the constant 1 when it is clear, so one multiplier performs both square-and-multiply and plain squaring.

Operands enter through a valid/ready port. A set is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from acceptance until the result has been handed off. The result leaves through a second valid/ready port. While `out_valid` is high and `out_ready` is low, the engine stalls and holds the result unchanged.

Top module: `gf_exp_msb`

## Requirements
- R1: Out of reset `in_ready` is 1 and `out_valid` is 0.
- R2: An operand set is captured only on an edge with `in_valid` and `in_ready` both high, and `in_ready` is 0 from the next cycle until the result is handed off. Changes on the input port while busy have no effect on the result.
- R3: `out_result` equals `in_base` raised to `in_exp`, modulo x^M + `in_poly`. Bit i of every M-bit field value is the coefficient of x^i.
- R4: An exponent of 0 yields the value 1, for any base.
- R5: An exponent of 1 yields the base unchanged. An exponent with only bit M-1 set yields the base squared M-1 times.
- R6: For a nonzero base and an irreducible polynomial, an exponent of 2^M-1 yields 1. A zero base with a nonzero exponent yields 0.
- R7: `out_valid` first rises (M-1)·(M+2)+1 clock edges after the accepting edge, whatever the exponent value.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_result` does not change.
- R9: After the edge on which `out_valid` and `out_ready` are both 1, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Engine idle and able to take an operand set |
| in_base | input | M | Base element |
| in_exp | input | M | Exponent, unsigned integer |
| in_poly | input | M | Field polynomial, coefficients x^0..x^(M-1); x^M is implied |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | M | base^exp mod polynomial |

## Verification
The bench targets four corner cases.

- Zero exponent: a design that seeds with the base, or that runs one step too many, returns the base or its square instead of 1.
- Exponents of 1 and 2^(M-1): an error in the top-bit seed or in the bit order produces a wrong power.
- Multiplicative inverses and 2^M-1 powers: an error in either reduction pass or in the carry handling shows up here.
- Operand changes while busy, and a stalled consumer: a design that samples inputs late, or drops or alters a held result, is caught. The bench also measures latency, which reveals a lost or extra cycle in the launch/wait sequence.

// File: rtl/gf_exp_pkg.sv
package gf_exp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_INIT   = 3'd1,
    ST_LAUNCH = 3'd2,
    ST_RUN    = 3'd3,
    ST_FINISH = 3'd4
  } exp_state_t;
endpackage

// File: rtl/gf_mulx2.sv
// Combinational v * x^2 mod P, built as two chained multiply-by-x stages.
module gf_mulx2 #(
  parameter int M = 8
) (
  input  logic [M-1:0] v,
  input  logic [M-1:0] poly,
  output logic [M-1:0] y
);
  logic [M-1:0] stage [0:2];

  assign stage[0] = v;

  for (genvar s = 0; s < 2; s++) begin : g_stage
    logic carry;
    assign carry = stage[s][M-1];
    assign stage[s+1][0] = carry & poly[0];
    for (genvar i = 1; i < M; i++) begin : g_bit
      assign stage[s+1][i] = stage[s][i-1] ^ (carry & poly[i]);
    end
  end

  assign y = stage[2];
endmodule

// File: rtl/gf_ab2_unit.sv
// Bit-serial X*Y^2 mod P; scans Y from MSB, M update cycles per operation.
module gf_ab2_unit #(
  parameter int M = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] x_op,
  input  logic [M-1:0] y_op,
  input  logic [M-1:0] poly,
  output logic         busy,
  output logic         done,
  output logic [M-1:0] prod
);
  localparam int CW = $clog2(M + 1);

  logic [M-1:0] acc_q, ysh_q, acc_sq;
  logic [CW-1:0] cnt_q;

  gf_mulx2 #(.M(M)) u_sq (
    .v   (acc_q),
    .poly(poly),
    .y   (acc_sq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ysh_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (start) begin
      acc_q <= '0;
      ysh_q <= y_op;
      cnt_q <= CW'(M);
      done  <= 1'b0;
    end else if (cnt_q != '0) begin
      acc_q <= acc_sq ^ (x_op & {M{ysh_q[M-1]}});
      ysh_q <= {ysh_q[M-2:0], 1'b0};
      cnt_q <= cnt_q - 1'b1;
      done  <= (cnt_q == CW'(1));
    end else begin
      done  <= 1'b0;
    end
  end

  assign busy = (cnt_q != '0);
  assign prod = acc_q;

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/gf_exp_msb.sv
module gf_exp_msb
  import gf_exp_pkg::*;
#(
  parameter int M = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [M-1:0] in_base,
  input  logic [M-1:0] in_exp,
  input  logic [M-1:0] in_poly,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [M-1:0] out_result
);
  localparam int IW = (M > 2) ? $clog2(M) : 1;
  localparam logic [M-1:0] ONE = {{(M-1){1'b0}}, 1'b1};

  exp_state_t   state_q;
  logic [M-1:0] base_q, exp_q, poly_q, run_q;
  logic [IW-1:0] idx_q;
  logic         mul_start, mul_busy, mul_done;
  logic [M-1:0] mul_x, mul_prod;

  assign mul_start = (state_q == ST_LAUNCH);
  assign mul_x     = exp_q[idx_q] ? base_q : ONE;

  gf_ab2_unit #(.M(M)) u_ab2 (
    .clk  (clk),
    .rst_n(rst_n),
    .start(mul_start),
    .x_op (mul_x),
    .y_op (run_q),
    .poly (poly_q),
    .busy (mul_busy),
    .done (mul_done),
    .prod (mul_prod)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      exp_q   <= '0;
      poly_q  <= '0;
      run_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (in_valid) begin
          base_q  <= in_base;
          exp_q   <= in_exp;
          poly_q  <= in_poly;
          state_q <= ST_INIT;
        end
        ST_INIT: begin
          run_q   <= exp_q[M-1] ? base_q : ONE;
          idx_q   <= IW'(M - 2);
          state_q <= ST_LAUNCH;
        end
        ST_LAUNCH: state_q <= ST_RUN;
        ST_RUN: if (mul_done) begin
          run_q <= mul_prod;
          if (idx_q == '0) state_q <= ST_FINISH;
          else begin
            idx_q   <= idx_q - 1'b1;
            state_q <= ST_LAUNCH;
          end
        end
        ST_FINISH: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready   = (state_q == ST_IDLE);
  assign out_valid  = (state_q == ST_FINISH);
  assign out_result = run_q;

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));
  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));
  // R7
  done_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_done |-> (state_q == ST_RUN));
  // R7
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (idx_q <= IW'(M - 2)));
  // R2
  idle_mul_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mul_busy);
endmodule

// File: tb/test_gf_exp_msb.sv
module test_gf_exp_msb;
  localparam int M = 8;
  localparam logic [M-1:0] POLY = 8'h1B;
  localparam int LAT = (M - 1) * (M + 2) + 1;
  localparam int NV = 12;
  // {base, exponent, expected}
  localparam logic [23:0] VEC [NV] = '{
    {8'h02, 8'h08, 8'h1B}, {8'h53, 8'hFE, 8'hCA}, {8'h02, 8'hFE, 8'h8D},
    {8'h03, 8'hFE, 8'hF6}, {8'h03, 8'hFF, 8'h01}, {8'h53, 8'h00, 8'h01},
    {8'h57, 8'h01, 8'h57}, {8'h00, 8'h05, 8'h00}, {8'h01, 8'hC3, 8'h01},
    {8'h02, 8'h02, 8'h04}, {8'hA7, 8'hFF, 8'h01}, {8'h00, 8'h00, 8'h01}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [M-1:0] in_base = '0, in_exp = '0, in_poly = POLY;
  logic in_ready, out_valid;
  logic [M-1:0] out_result;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  gf_exp_msb #(.M(M)) i_gf_exp_msb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_base(in_base), .in_exp(in_exp), .in_poly(in_poly),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
  );

  function automatic logic [M-1:0] gmul(logic [M-1:0] a, logic [M-1:0] b);
    logic [M-1:0] r = '0;
    for (int i = 0; i < M; i++) begin
      if (b[i]) r ^= a;
      a = a[M-1] ? ({a[M-2:0], 1'b0} ^ POLY) : {a[M-2:0], 1'b0};
    end
    return r;
  endfunction

  // independent LSB-first model
  function automatic logic [M-1:0] gpow(logic [M-1:0] a, logic [M-1:0] e);
    logic [M-1:0] r = 1;
    for (int i = 0; i < M; i++) begin
      if (e[i]) r = gmul(r, a);
      a = gmul(a, a);
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // issue one operand set, optionally disturb inputs while busy
  task automatic run_op(logic [M-1:0] a, logic [M-1:0] e, bit disturb,
                        output logic [M-1:0] res, output int lat);
    @(negedge clk);
    in_base = a; in_exp = e; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    lat = 0;
    if (disturb) begin
      in_base = ~a; in_exp = e ^ 8'h5A;
    end else in_valid = 1'b0;
    while (!out_valid && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0;
    res = out_result;
  endtask

  initial begin
    logic [M-1:0] res;
    int lat;
    #1;
    check("R1 in_ready at reset", in_ready, 1);
    check("R1 out_valid at reset", out_valid, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_ready after reset", in_ready, 1);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][23:16], VEC[i][15:8], 1'b0, res, lat);
      check("R3 table vector", res, VEC[i][7:0]);
      check("R7 latency", lat, LAT);
    end

    for (int i = 0; i < 8; i++) begin
      logic [M-1:0] a = M'(i * 37 + 5), e = M'(i * 53 + 11);
      run_op(a, e, 1'b0, res, lat);
      check("R3 model", res, gpow(a, e));
    end

    run_op(8'h9C, 8'h00, 1'b0, res, lat);
    check("R4 zero exponent", res, 1);
    run_op(8'hE1, 8'h01, 1'b0, res, lat);
    check("R5 exponent one", res, 8'hE1);
    run_op(8'h02, 8'h80, 1'b0, res, lat);
    check("R5 top bit only", res, gpow(8'h02, 8'h80));
    run_op(8'h6D, 8'hFF, 1'b0, res, lat);
    check("R6 order power", res, 1);
    run_op(8'h00, 8'h80, 1'b0, res, lat);
    check("R6 zero base", res, 0);

    // R2 disturbed inputs while busy
    run_op(8'h35, 8'hB7, 1'b1, res, lat);
    check("R2 input change ignored", res, gpow(8'h35, 8'hB7));
    check("R2 no ready while busy", in_ready, 0);

    // R8 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    run_op(8'h4B, 8'h2D, 1'b0, res, lat);
    repeat (5) @(negedge clk);
    check("R8 valid held", out_valid, 1);
    check("R8 data held", out_result, gpow(8'h4B, 8'h2D));
    check("R8 no new accept", in_ready, 0);
    out_ready = 1'b1;
    @(negedge clk);
    check("R9 ready after handoff", in_ready, 1);
    check("R9 valid cleared", out_valid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule